// File: doc/BRIEF.md
# Masked Multi-Output Compare Forcing Unit

This block runs a free-running up-counter and compares it with a master compare register. When the two are equal on an advancing clock edge, a single event forces any chosen subset of the output pins to programmed levels. A mask register picks which pins the event drives. A data register gives the level that each picked pin takes. Pins outside the mask are left alone by the event. Each pin can also be loaded on its own through a per-channel hold-or-load input.

Software-side logic programs the compare value, the mask and the data through a small write port. It then watches a sticky match flag, which is cleared by writing a one to it. The outputs are registered, so every change appears on the cycle after the edge that caused it.

Top module: `cmp_force_unit`

## Requirements
- R1: While `rst` is high and after it falls, `pin_out` is all zeros and `match_flag` is 0. The mask and data registers reset to zero, so a match that follows reset leaves every pin at 0.
- R2: The counter is CNT_W (16) bits wide and starts at 0. It steps by one on each clock edge where `cnt_en` is 1 and holds when `cnt_en` is 0. It wraps from 0xFFFF to 0x0000, so two matches with the enable held high are exactly 65536 edges apart.
- R3: A match happens on a clock edge where `cnt_en` is 1 and the counter equals the compare register. `match_flag` reads 1 from the cycle after that edge and not before.
- R4: On a match, every pin whose mask bit is 1 takes the value of its data bit from the cycle after the match. Bit k of the mask and of the data controls `pin_out[k]`, which is output pin k+1.
- R5: On a match, a pin whose mask bit is 0 keeps its level.
- R6: When no match drives a pin, `chan_load[k]` = 1 loads `chan_level[k]` into `pin_out[k]` on the next cycle. When `chan_load[k]` = 0, the pin holds its level.
- R7: When a match and a per-channel load hit a masked pin on the same edge, the match decides the pin's level.
- R8: `match_flag` is sticky. A write to the flag address with bit 0 = 1 clears it. A write with bit 0 = 0 has no effect. A match on the same edge as a clear leaves the flag at 1.
- R9: A write takes effect when `wr_en` = 1. `wr_sel` = 0 writes the compare value from `wr_data[15:0]`. `wr_sel` = 1 writes the mask and `wr_sel` = 2 writes the data, both from `wr_data[4:0]`. `wr_sel` = 3 is the flag clear.
- R10: No match occurs while `cnt_en` is 0, even when the stalled counter equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter advance enable; also qualifies a match |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 compare, 1 mask, 2 data, 3 flag clear |
| wr_data | input | 16 | Write data |
| chan_load | input | 5 | Per-pin load request |
| chan_level | input | 5 | Per-pin level used on a load |
| pin_out | output | 5 | Registered output-compare pins |
| match_flag | output | 1 | Sticky master match flag |

## Verification
The bench checks the exact edge of a match, around stalls of the enable and across a full counter wrap. A design that matched while the counter was stalled, or that was off by one edge, would raise the flag a cycle early or late, or raise it repeatedly. Tests that combine a load with a match on the same edge show whether the master match takes priority on masked pins and whether unmasked pins are left alone. A swapped priority or a leaking mask leaves the wrong levels on the pins. The flag is driven with a clear that writes zero and with a clear that lands on a match. A flag that clears on any write, or that lets the clear win, fails those checks.

// File: rtl/cmp_force_pkg.sv
package cmp_force_pkg;
  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_DATA = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cmp_force_timebase.sv
module cmp_force_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign match_o = cnt_en && (cnt_q == cmp_val);

  // R2: wrap to zero
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_q == CNT_MAX) |=> (cnt_q == '0));
  // R2: stall holds value
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_q));
  // R10: no match while stalled
  p_nomatch_r10: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |-> !match_o);
endmodule

// File: rtl/cmp_force_regs.sv
module cmp_force_regs
  import cmp_force_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_PINS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic                match,
  output logic [CNT_W-1:0]    cmp_val,
  output logic [NUM_PINS-1:0] mask,
  output logic [NUM_PINS-1:0] data,
  output logic                flag
);
  reg_sel_e sel;
  logic     clr_req;

  assign sel     = reg_sel_e'(wr_sel);
  assign clr_req = wr_en && (sel == SEL_FLAG) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '0;
      mask    <= '0;
      data    <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_CMP:  cmp_val <= wr_data;
        SEL_MASK: mask    <= wr_data[NUM_PINS-1:0];
        SEL_DATA: data    <= wr_data[NUM_PINS-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (match)   flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  // R3 / R8: a match always leaves the flag set
  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    match |=> flag);
  // R8: flag is sticky without a clear
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag);
endmodule

// File: rtl/cmp_force_pins.sv
module cmp_force_pins #(
  parameter int NUM_PINS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                match,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] data,
  input  logic [NUM_PINS-1:0] load,
  input  logic [NUM_PINS-1:0] level,
  output logic [NUM_PINS-1:0] pins
);
  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic forced;
    assign forced = match && mask[k];

    always_ff @(posedge clk) begin
      if (rst)          pins[k] <= 1'b0;
      else if (forced)  pins[k] <= data[k];
      else if (load[k]) pins[k] <= level[k];
    end

    // R4 / R7: masked pin takes data bit, over any load
    p_force_r4: assert property (@(posedge clk) disable iff (rst)
      (match && mask[k]) |=> (pins[k] == $past(data[k])));
    // R5 / R6: no match on this pin and no load keeps level
    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
      (!(match && mask[k]) && !load[k]) |=> $stable(pins[k]));
  end
endmodule

// File: rtl/cmp_force_unit.sv
module cmp_force_unit #(
  parameter int CNT_W    = 16,
  parameter int NUM_PINS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_en,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [NUM_PINS-1:0] chan_load,
  input  logic [NUM_PINS-1:0] chan_level,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                match_flag
);
  logic                match;
  logic [CNT_W-1:0]    cmp_val;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] data;

  cmp_force_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .cmp_val (cmp_val),
    .match_o (match)
  );

  cmp_force_regs #(.CNT_W(CNT_W), .NUM_PINS(NUM_PINS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .match   (match),
    .cmp_val (cmp_val),
    .mask    (mask),
    .data    (data),
    .flag    (match_flag)
  );

  cmp_force_pins #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk   (clk),
    .rst   (rst),
    .match (match),
    .mask  (mask),
    .data  (data),
    .load  (chan_load),
    .level (chan_level),
    .pins  (pin_out)
  );

  // R1: reset clears the outputs
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && !match_flag));
endmodule

// File: tb/test_cmp_force_unit.sv
module test_cmp_force_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic [4:0]  chan_load = '0;
  logic [4:0]  chan_level = '0;
  logic [4:0]  pin_out;
  logic        match_flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] m_cnt = '0;
  logic [15:0] m_cmp = '0;
  logic [4:0]  m_mask = '0;
  logic [4:0]  m_data = '0;
  logic [4:0]  exp_pins = '0;
  logic        exp_flag = 1'b0;

  always #4 clk = ~clk;

  cmp_force_unit i_cmp_force_unit (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .chan_load(chan_load), .chan_level(chan_level),
    .pin_out(pin_out), .match_flag(match_flag)
  );

  task automatic check(string req, logic [4:0] ep, logic ef);
    checks++;
    if (pin_out !== ep || match_flag !== ef) begin
      errors++;
      $display("FAIL %s: actual pins=%b flag=%b expected pins=%b flag=%b",
               req, pin_out, match_flag, ep, ef);
    end
  endtask

  task automatic check_model(string req);
    check(req, exp_pins, exp_flag);
  endtask

  task automatic tick();
    logic       mt;
    logic [4:0] np;
    mt = cnt_en && (m_cnt == m_cmp);
    np = exp_pins;
    for (int i = 0; i < 5; i++) begin
      if (mt && m_mask[i]) np[i] = m_data[i];
      else if (chan_load[i]) np[i] = chan_level[i];
    end
    if (mt) exp_flag = 1'b1;
    else if (wr_en && wr_sel == 2'd3 && wr_data[0]) exp_flag = 1'b0;
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_cmp = wr_data;
        2'd1: m_mask = wr_data[4:0];
        2'd2: m_data = wr_data[4:0];
        default: ;
      endcase
    end
    exp_pins = np;
    if (cnt_en) m_cnt = m_cnt + 16'd1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    chan_load = '0;
  endtask

  task automatic wreg(logic [1:0] sel, logic [15:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    tick();
  endtask

  task automatic t_reset();
    check("R1 reset state", 5'b00000, 1'b0);
    wreg(2'd3, 16'h0001);
    cnt_en = 1'b1;
    tick();
    cnt_en = 1'b0;
    check("R1 zero mask after reset", 5'b00000, 1'b1);
    check_model("R3 match at reset compare");
  endtask

  task automatic t_flag_clear();
    wreg(2'd3, 16'h0000);
    check("R8 write zero keeps flag", exp_pins, 1'b1);
    wreg(2'd3, 16'h0001);
    check("R8 write one clears flag", exp_pins, 1'b0);
  endtask

  task automatic t_masked_force();
    wreg(2'd1, 16'h0015);
    wreg(2'd2, 16'h0005);
    wreg(2'd0, m_cnt + 16'd4);
    cnt_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      check_model("R3 match timing");
    end
    cnt_en = 1'b0;
    check("R4 masked pins forced", 5'b00101, 1'b1);
    wreg(2'd2, 16'h0010);
    wreg(2'd3, 16'h0001);
    wreg(2'd0, m_cnt);
    cnt_en = 1'b1;
    tick();
    cnt_en = 1'b0;
    check("R5 unmasked pins kept, R4 set pin5", 5'b10000, 1'b1);
  endtask

  task automatic t_stall();
    wreg(2'd3, 16'h0001);
    wreg(2'd0, m_cnt);
    for (int i = 0; i < 4; i++) tick();
    check("R10 no match while stalled", exp_pins, 1'b0);
    wreg(2'd0, m_cnt + 16'd3);
    for (int i = 0; i < 9; i++) begin
      cnt_en = (i % 3 != 1);
      tick();
      check_model("R2 step and hold");
    end
    cnt_en = 1'b0;
  endtask

  task automatic t_load_priority();
    chan_load = 5'b11111; chan_level = 5'b11111;
    tick();
    check("R6 load all pins", 5'b11111, exp_flag);
    chan_load = 5'b00100; chan_level = 5'b00000;
    tick();
    check("R6 single load", 5'b11011, exp_flag);
    tick();
    check("R6 no load holds", 5'b11011, exp_flag);
    wreg(2'd1, 16'h0003);
    wreg(2'd2, 16'h0000);
    wreg(2'd0, m_cnt);
    chan_load = 5'b11111; chan_level = 5'b11111;
    cnt_en = 1'b1;
    tick();
    cnt_en = 1'b0;
    check("R7 match beats load", 5'b11100, 1'b1);
  endtask

  task automatic t_set_beats_clear();
    wreg(2'd3, 16'h0001);
    wreg(2'd0, m_cnt);
    cnt_en = 1'b1;
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h0001;
    tick();
    cnt_en = 1'b0;
    check("R8 set beats clear", exp_pins, 1'b1);
    check_model("R9 flag address");
  endtask

  task automatic t_wrap();
    wreg(2'd0, m_cnt + 16'd2);
    cnt_en = 1'b1;
    tick(); tick(); tick();
    check("R3 first match", exp_pins, 1'b1);
    wreg(2'd3, 16'h0001);
    for (int i = 0; i < 65534; i++) tick();
    check("R2 no match before wrap", exp_pins, 1'b0);
    tick();
    check("R2 match after full wrap", exp_pins, 1'b1);
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_flag_clear();
    t_masked_force();
    t_stall();
    t_load_priority();
    t_set_beats_clear();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule